// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block owns the fetch address of a small controller with a 13-bit program space. Every cycle it looks at the instruction word fetched from the address it currently drives. From that word it picks the next address: the following word, a jump target, a call target, or an address taken from a hardware return stack. A separate skip unit raises a skip request when a test instruction passes. The sequencer then steps over the following word by advancing by two.

Table-lookup loads take two machine cycles. For the first of them the fetch address stays where it is. During the second cycle the word on the instruction input is not decoded. The return stack has a parameterised depth. A call into a full stack and a return from an empty stack each set a flag that stays set until reset.

Top module: `prog_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the fetch address is 0, both flags are clear and the return stack is empty.
- R2: An instruction that is not one of the kinds below advances the fetch address by 1 on the next cycle, wrapping from 8191 to 0. This includes the no-operation word 0xFC0F and 111111-prefixed words whose low nibble is not 0011.
- R3: A word with bits [15:13] = 101 (jump) loads bits [12:0] into the fetch address on the next cycle.
- R4: A word with bits [15:13] = 100 (call) pushes the current address + 1 onto the return stack and loads bits [12:0]. Returns give addresses back in last-in, first-out order.
- R5: A word with bits [15:10] = 111111, [9:8] = 10 and [3:0] = 0011 (return) loads the address popped from the stack.
- R6: A word with bits [15:10] = 111111, [9:8] = 11 and [3:0] = 0011 (return and skip) loads the popped address + 1.
- R7: A high skip request during a cycle that decodes an R2 instruction advances the address by 2, modulo 8192. A skip request has no effect on jump, call, return or two-cycle words.
- R8: A word with bits [15:10] = 111110 (two-cycle load) keeps the fetch address unchanged for one cycle. In that second cycle the instruction input and the skip request are ignored, and the address then advances by 1.
- R9: A call while the stack already holds DEPTH entries sets the overflow flag and still loads the target. The new return address is dropped, and the existing entries are kept.
- R10: A return of either kind from an empty stack sets the underflow flag and uses 0 as the popped address.
- R11: Once set, each flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word fetched from fetch_addr |
| skip_req | input | 1 | Skip request from the skip unit |
| fetch_addr | output | 13 | Current program counter / fetch address |
| stack_ovf | output | 1 | Sticky flag, call into a full stack |
| stack_unf | output | 1 | Sticky flag, return from an empty stack |

## Verification
The bench builds the block with the default depth of 4. This lets a burst of five nested calls reach overflow, and five returns after that reach underflow, within a few dozen cycles. A long pseudo-random stream then drifts in and out of both stack limits many times. The same stream mixes skips, two-cycle loads and jumps near address 8191 to exercise wrap-around.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    localparam int ADDR_W  = 13;
    localparam int INSTR_W = 16;

    localparam logic [2:0] PFX_CALL = 3'b100;
    localparam logic [2:0] PFX_JUMP = 3'b101;
    localparam logic [5:0] OPC_MISC = 6'b111111;
    localparam logic [5:0] OPC_LOAD = 6'b111110;
    localparam logic [1:0] SEL_RET  = 2'b10;
    localparam logic [1:0] SEL_RETS = 2'b11;
    localparam logic [3:0] SUB_RET  = 4'b0011;

    typedef enum logic [2:0] {
        OP_SEQ,
        OP_JUMP,
        OP_CALL,
        OP_RET,
        OP_RETSKIP,
        OP_TWO
    } op_kind_e;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import prog_seq_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output op_kind_e           kind,
    output logic [ADDR_W-1:0]  target
);

    logic is_misc;
    logic is_ret_sub;

    always_comb begin
        is_misc    = (instr[15:10] == OPC_MISC);
        is_ret_sub = (instr[3:0] == SUB_RET);
        target     = instr[ADDR_W-1:0];
        kind       = OP_SEQ;
        if (instr[15:13] == PFX_CALL) begin
            kind = OP_CALL;
        end else if (instr[15:13] == PFX_JUMP) begin
            kind = OP_JUMP;
        end else if (instr[15:10] == OPC_LOAD) begin
            kind = OP_TWO;
        end else if (is_misc && is_ret_sub && instr[9:8] == SEL_RET) begin
            kind = OP_RET;
        end else if (is_misc && is_ret_sub && instr[9:8] == SEL_RETS) begin
            kind = OP_RETSKIP;
        end
    end

endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import prog_seq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] top_addr,
    output logic              full,
    output logic              empty,
    output logic [CW-1:0]     level
);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] slot;
        logic [CW-1:0]                cnt;
    } stk_state_t;

    stk_state_t st_d, st_q;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign level = st_q.cnt;

    always_comb begin
        st_d     = st_q;
        top_addr = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!empty && CW'(i) == st_q.cnt - CW'(1)) begin
                top_addr = st_q.slot[i];
            end
        end
        if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == st_q.cnt) begin
                    st_d.slot[i] = push_addr;
                end
            end
            st_d.cnt = st_q.cnt + CW'(1);
        end else if (pop && !empty) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               skip_req,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               stack_ovf,
    output logic               stack_unf
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              hold;
        logic              ovf;
        logic              unf;
    } seq_state_t;

    seq_state_t cur_q, nxt_d;

    op_kind_e          kind;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] top_addr;
    logic              push, pop;
    logic              stk_full, stk_empty;
    logic [CW-1:0]     stk_level;
    logic [ADDR_W-1:0] pc_inc1, pc_inc2;
    logic              hold_w;

    seq_decode u_dec (
        .instr  (instr),
        .kind   (kind),
        .target (target)
    );

    ret_stack #(.DEPTH(DEPTH)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_addr (pc_inc1),
        .top_addr  (top_addr),
        .full      (stk_full),
        .empty     (stk_empty),
        .level     (stk_level)
    );

    assign pc_inc1 = cur_q.pc + ADDR_W'(1);
    assign pc_inc2 = cur_q.pc + ADDR_W'(2);
    assign hold_w  = cur_q.hold;

    always_comb begin
        nxt_d = cur_q;
        push  = 1'b0;
        pop   = 1'b0;
        if (cur_q.hold) begin
            nxt_d.pc   = pc_inc1;
            nxt_d.hold = 1'b0;
        end else begin
            unique case (kind)
                OP_SEQ: begin
                    nxt_d.pc = skip_req ? pc_inc2 : pc_inc1;
                end
                OP_TWO: begin
                    nxt_d.hold = 1'b1;
                end
                OP_JUMP: begin
                    nxt_d.pc = target;
                end
                OP_CALL: begin
                    push     = 1'b1;
                    nxt_d.pc = target;
                    if (stk_full) nxt_d.ovf = 1'b1;
                end
                OP_RET: begin
                    pop      = 1'b1;
                    nxt_d.pc = top_addr;
                    if (stk_empty) nxt_d.unf = 1'b1;
                end
                OP_RETSKIP: begin
                    pop      = 1'b1;
                    nxt_d.pc = top_addr + ADDR_W'(1);
                    if (stk_empty) nxt_d.unf = 1'b1;
                end
                default: begin
                    nxt_d.pc = pc_inc1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign fetch_addr = cur_q.pc;
    assign stack_ovf  = cur_q.ovf;
    assign stack_unf  = cur_q.unf;

endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk
    import prog_seq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr,
    input logic [ADDR_W-1:0]  fetch_addr,
    input logic               stack_ovf,
    input logic               stack_unf,
    input logic               hold,
    input logic [CW-1:0]      level
);

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && instr[15:13] == PFX_JUMP) |=> fetch_addr == $past(instr[ADDR_W-1:0])); // R3

    AST_CALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && instr[15:13] == PFX_CALL) |=> fetch_addr == $past(instr[ADDR_W-1:0])); // R4

    AST_TWO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && instr[15:10] == OPC_LOAD) |=> (hold && fetch_addr == $past(fetch_addr))); // R8

    AST_HOLD_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!hold && fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(1)))); // R8

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf |=> stack_ovf); // R11

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stack_unf |=> stack_unf); // R11

endmodule

bind prog_seq prog_seq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr      (instr),
    .fetch_addr (fetch_addr),
    .stack_ovf  (stack_ovf),
    .stack_unf  (stack_unf),
    .hold       (hold_w),
    .level      (stk_level)
);

// File: tb/prog_seq_test.sv
module prog_seq_test;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic        skip_req = 1'b0;
    logic [12:0] fetch_addr;
    logic        stack_ovf, stack_unf;

    int n_cmp = 0;
    int n_bad = 0;

    int          m_pc;
    bit          m_hold, m_ovf, m_unf;
    int          m_stk[$];

    always #2 clk = ~clk;

    prog_seq #(.DEPTH(DEPTH)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr      (instr),
        .skip_req   (skip_req),
        .fetch_addr (fetch_addr),
        .stack_ovf  (stack_ovf),
        .stack_unf  (stack_unf)
    );

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic compare(input string req);
        n_cmp++;
        if (fetch_addr !== 13'(m_pc) || stack_ovf !== m_ovf || stack_unf !== m_unf) begin
            n_bad++;
            $display("FAIL %s: actual pc=%0d ovf=%0b unf=%0b, expected pc=%0d ovf=%0b unf=%0b",
                     req, fetch_addr, stack_ovf, stack_unf, m_pc, m_ovf, m_unf);
        end
    endtask

    // Classify a word from the encodings listed in the requirements.
    function automatic string kind_of(input logic [15:0] w);
        if (w[15:13] == 3'b100) return "R4_call";
        if (w[15:13] == 3'b101) return "R3_jump";
        if (w[15:10] == 6'b111110) return "R8_two";
        if (w[15:10] == 6'b111111 && w[3:0] == 4'b0011 && w[9:8] == 2'b10) return "R5_ret";
        if (w[15:10] == 6'b111111 && w[3:0] == 4'b0011 && w[9:8] == 2'b11) return "R6_rets";
        return "R2_seq";
    endfunction

    task automatic step(input logic [15:0] w, input bit sk);
        string k;
        string req;
        int    ra;
        instr    = w;
        skip_req = sk;
        k = kind_of(w);
        if (m_hold) begin
            req    = "R8_hold";
            m_pc   = (m_pc + 1) % 8192;
            m_hold = 0;
        end else begin
            req = k;
            case (k)
                "R2_seq": begin
                    if (sk) req = "R7_skip";
                    m_pc = (m_pc + (sk ? 2 : 1)) % 8192;
                end
                "R3_jump": m_pc = int'(w[12:0]);
                "R4_call": begin
                    if (m_stk.size() < DEPTH) m_stk.push_back((m_pc + 1) % 8192);
                    else begin m_ovf = 1; req = "R9_ovf"; end
                    m_pc = int'(w[12:0]);
                end
                "R8_two": m_hold = 1;
                default: begin
                    if (m_stk.size() == 0) begin ra = 0; m_unf = 1; req = "R10_unf"; end
                    else ra = m_stk.pop_back();
                    m_pc = (k == "R6_rets") ? (ra + 1) % 8192 : ra;
                end
            endcase
        end
        if (m_ovf || m_unf) req = {req, "/R11"};
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        m_pc = 0; m_hold = 0; m_ovf = 0; m_unf = 0;
        m_stk.delete();
        compare("R1_in_reset");
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1_after_release");
    endtask

    function automatic logic [15:0] w_seq(input int r);
        logic [15:0] v;
        v = 16'(r);
        case (r % 4)
            0: return {3'b000, v[12:0]};
            1: return {3'b110, v[12:0]};
            2: return 16'hFC0F;
            default: return {8'b1111_1110, v[7:4], 4'b0101};
        endcase
    endfunction

    initial begin
        @(negedge clk);
        do_reset();
        // R2: sequential with assorted non-control words
        for (int i = 0; i < 6; i++) step(w_seq(i), 1'b0);
        // R7: skips on sequential, ignored on jump
        step(w_seq(7), 1'b1);
        step({3'b101, 13'd100}, 1'b1);
        step(w_seq(1), 1'b1);
        // R4/R5/R6 nested calls, LIFO returns
        step({3'b100, 13'd200}, 1'b1);
        step({3'b100, 13'd300}, 1'b0);
        step(w_seq(0), 1'b0);
        step(16'hFF03, 1'b1);
        step(16'hFE03, 1'b0);
        // R8: two-cycle load; second cycle word is a jump that must be ignored
        step({6'b111110, 10'h155}, 1'b0);
        step({3'b101, 13'd4000}, 1'b1);
        step(w_seq(2), 1'b0);
        // R2/R7 wrap around the top of the address space
        step({3'b101, 13'd8191}, 1'b0);
        step(w_seq(0), 1'b0);
        step({3'b101, 13'd8190}, 1'b0);
        step(w_seq(3), 1'b1);
        // R9: five calls into a depth-4 stack
        for (int i = 0; i < 5; i++) step({3'b100, 13'(1000 + 10 * i)}, 1'b0);
        step(w_seq(0), 1'b0);
        // R5/R10: drain and go past empty
        for (int i = 0; i < 5; i++) step(16'hFE03, 1'b0);
        step(16'hFF03, 1'b0);
        // R11: flags persist until reset
        for (int i = 0; i < 3; i++) step(w_seq(i), 1'b0);
        do_reset();
        // Pseudo-random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            int sel;
            logic [15:0] w;
            r   = int'($urandom() & 32'h7FFF_FFFF);
            sel = r % 10;
            case (sel)
                0: w = {3'b101, 13'(r >> 4)};
                1, 2: w = {3'b100, 13'(r >> 4)};
                3: w = 16'hFE03;
                4: w = 16'hFF03;
                5: w = {6'b111110, 10'(r >> 4)};
                default: w = w_seq(r >> 4);
            endcase
            step(w, 1'((r >> 20) & 1));
            if (i == 2000) do_reset();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule